// File: doc/BRIEF.md
# Nibble-Wide Framed Packet Sender for a Crossed Parallel Cable

This block pushes packets across a five-wire crossed parallel cable to a peer that answers on its own five status wires. Four of the outgoing wires carry a data nibble and the fifth is a handshake strobe. Every byte crosses in two halves. The low half goes first with the strobe high, and the high half follows with the strobe low. Each half waits for the peer to copy the strobe level back on its handshake wire.

A frame does not begin with a byte. The sender first parks a fixed start code on the data wires and waits for the peer to answer with its own code. The frame is then sent in this order:
- a two-byte length field;
- a block of address bytes taken from a configuration vector;
- a fixed two-byte type word;
- the payload;
- a one-byte additive checksum.

Nothing marks the end of the frame. The receiver stops counting when the length runs out, and the sender parks all wires at zero. Any wait that runs for too long abandons the frame and returns the block to idle.

The payload arrives as a valid/ready byte stream. Its byte count rides on the same beat as the first payload byte.

Top module: `nib_pkt_tx`

## Requirements
- R1: After reset, `line_out` is 0, `pay_ready` is 0 and `tmo_err` is 0.
- R2: When `pay_valid` is seen while idle, `line_out` becomes 5'h08 (data nibble 8, strobe bit 4 low). It stays there until `peer_stat[3:0]` equals 4'h1, and no byte is sent before that.
- R3: Each byte is sent as follows. First `line_out` = {1, byte[3:0]}, held until `peer_stat[4]` is 1. Then `line_out` = {0, byte[7:4]}, held until `peer_stat[4]` is 0. Bit 4 is the strobe on both buses, and bits 3:0 are data.
- R4: The byte order of a frame is: length low byte, length high byte, ADDR_BYTES address bytes (`hdr_addr[7:0]` first, rising), 8'h08, 8'h00, the payload bytes in stream order, and the checksum.
- R5: The length field equals `pay_len` + ADDR_BYTES + 2, taken modulo 65536 (that is `pay_len` + 14 with the defaults).
- R6: The checksum byte is the modulo-256 sum of the address bytes, the type word and the payload. The length bytes are not included.
- R7: `pay_len` is sampled on the beat that starts a frame, and that beat's byte is the first payload byte. Each payload byte is taken only when `pay_valid` and `pay_ready` are both high, and every byte of the frame is taken by its end.
- R8: A start beat with `pay_len` = 0 is consumed in the cycle the frame starts. Its byte is discarded, the frame has no payload, and the length field is ADDR_BYTES + 2.
- R9: Once the peer lowers its strobe after the high nibble of the checksum, `line_out` returns to 0 and the block is idle again.
- R10: A wait for the peer's start reply, for the peer strobe, or for the next payload byte that lasts WAIT_LIMIT cycles ends the frame. `tmo_err` then pulses for one cycle, `line_out` is 0 in that cycle, and a following frame is sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pay_valid | input | 1 | A payload beat is presented |
| pay_ready | output | 1 | The presented beat is consumed in this cycle |
| pay_data | input | 8 | Payload byte |
| pay_len | input | LEN_W | Payload byte count, valid with the first beat |
| hdr_addr | input | 8*ADDR_BYTES | Address bytes of the header, byte 0 in the low bits |
| peer_stat | input | 5 | Peer wires: [3:0] data, [4] peer strobe |
| line_out | output | 5 | Cable wires: [3:0] data nibble, [4] strobe |
| tmo_err | output | 1 | One-cycle pulse when a wait times out |

## Verification
The hardest case to reach from the ports is a payload stream that dries up in the middle of a frame. This happens after the start exchange and the whole header have already crossed. To get there, the bench source stops asserting `pay_valid` after a chosen number of payload bytes, while the bench peer keeps answering every strobe. The stall then falls exactly on the fetch of the next payload byte, and the timeout has to come from that fetch wait and not from a handshake wait. A second hard case is a length field whose high byte is nonzero. To reach it, a frame with a payload of several hundred bytes is streamed through the same sweep that covers every payload length from 0 to 20.

// File: rtl/npt_pkg.sv
`timescale 1ns/1ps
package npt_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_LOAD,
      S_LO,
      S_HI
   } tx_state_e;

   localparam logic [3:0] START_CODE = 4'h8;
   localparam logic [3:0] REPLY_CODE = 4'h1;
   localparam logic [7:0] TYPE_HI    = 8'h08;
   localparam logic [7:0] TYPE_LO    = 8'h00;
endpackage

// File: rtl/npt_wait_timer.sv
`timescale 1ns/1ps
module npt_wait_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expired
);
   if (LIMIT < 0) begin : g_bad_limit
      $error("npt_wait_timer: LIMIT must not be negative");
   end

   generate
      if (LIMIT == 0) begin : g_off
         assign expired = 1'b0;
      end else begin : g_on
         localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
         logic [CW-1:0] cnt;

         assign expired = run && (cnt == CW'(LIMIT - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!run || clr)   cnt <= '0;
            else if (!expired)      cnt <= cnt + 1'b1;
         end

         // R10: the wait counter never passes the limit
         a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/npt_byte_src.sv
`timescale 1ns/1ps
module npt_byte_src
   import npt_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int ADDR_BYTES = 12,
   parameter int IDX_W      = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_go,
   input  logic [LEN_W-1:0]        pay_len,
   input  logic [IDX_W-1:0]        idx,
   input  logic [7:0]              pay_data,
   input  logic [8*ADDR_BYTES-1:0] hdr_addr,
   input  logic                    acc_en,
   output logic [7:0]              cur_byte,
   output logic                    is_pay,
   output logic                    is_last
);
   localparam int HDR_B     = ADDR_BYTES + 2;
   localparam int PAY_FIRST = HDR_B + 2;

   logic [LEN_W-1:0] len_q;
   logic [7:0]       sum_q;
   logic [15:0]      frame_len;
   logic [IDX_W-1:0] pay_end;
   logic [7:0]       addr_b [ADDR_BYTES];

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
      assign addr_b[g] = hdr_addr[8*g +: 8];
   end

   assign frame_len = 16'(len_q) + 16'(HDR_B);
   assign pay_end   = IDX_W'(len_q) + IDX_W'(PAY_FIRST);
   assign is_pay    = (idx >= IDX_W'(PAY_FIRST)) && (idx < pay_end);
   assign is_last   = (idx == pay_end);

   always_comb begin
      cur_byte = sum_q;
      if (idx == '0)                          cur_byte = frame_len[7:0];
      else if (idx == IDX_W'(1))              cur_byte = frame_len[15:8];
      else if (idx == IDX_W'(ADDR_BYTES + 2)) cur_byte = TYPE_HI;
      else if (idx == IDX_W'(ADDR_BYTES + 3)) cur_byte = TYPE_LO;
      else if (is_pay)                        cur_byte = pay_data;
      else begin
         for (int k = 0; k < ADDR_BYTES; k++)
            if (idx == IDX_W'(k + 2)) cur_byte = addr_b[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         sum_q <= '0;
      end else if (frame_go) begin
         len_q <= pay_len;
         sum_q <= '0;
      end else if (acc_en) begin
         sum_q <= sum_q + cur_byte;
      end
   end

   // R6: the two length slots are never folded into the checksum
   a_r6_len_not_summed: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !frame_go) |-> (idx > IDX_W'(1)));
endmodule

// File: rtl/nib_pkt_tx.sv
`timescale 1ns/1ps
module nib_pkt_tx
   import npt_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int ADDR_BYTES = 12,
   parameter int WAIT_LIMIT = 4096
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pay_valid,
   output logic                    pay_ready,
   input  logic [7:0]              pay_data,
   input  logic [LEN_W-1:0]        pay_len,
   input  logic [8*ADDR_BYTES-1:0] hdr_addr,
   input  logic [4:0]              peer_stat,
   output logic [4:0]              line_out,
   output logic                    tmo_err
);
   localparam int IDX_W = LEN_W + 2;

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("nib_pkt_tx: LEN_W must lie in 1..16");
   end
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("nib_pkt_tx: ADDR_BYTES must be at least 1");
   end

   tx_state_e        st;
   logic [IDX_W-1:0] idx;
   logic [4:0]       drv_q;
   logic [3:0]       hi_q;
   logic             err_q;

   logic             step, expired, load_ok, frame_go, acc_en;
   logic [7:0]       cur_byte;
   logic             is_pay, is_last;
   logic             peer_hs;
   logic [3:0]       peer_dat;

   assign peer_hs  = peer_stat[4];
   assign peer_dat = peer_stat[3:0];
   assign load_ok  = (st == S_LOAD) && (!is_pay || pay_valid);
   assign frame_go = (st == S_IDLE) && pay_valid;
   assign acc_en   = load_ok && (idx > IDX_W'(1)) && !is_last;
   assign pay_ready = (frame_go && (pay_len == '0)) ||
                      ((st == S_LOAD) && is_pay && pay_valid);

   always_comb begin
      unique case (st)
         S_IDLE:  step = pay_valid;
         S_START: step = (peer_dat == REPLY_CODE);
         S_LOAD:  step = load_ok;
         S_LO:    step = peer_hs;
         S_HI:    step = !peer_hs;
         default: step = 1'b0;
      endcase
   end

   npt_byte_src #(
      .LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .pay_len(pay_len),
      .idx(idx), .pay_data(pay_data), .hdr_addr(hdr_addr), .acc_en(acc_en),
      .cur_byte(cur_byte), .is_pay(is_pay), .is_last(is_last)
   );

   npt_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(st != S_IDLE), .clr(step),
      .expired(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         idx   <= '0;
         drv_q <= '0;
         hi_q  <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (step) begin
            unique case (st)
               S_IDLE: begin
                  st    <= S_START;
                  idx   <= '0;
                  drv_q <= {1'b0, START_CODE};
               end
               S_START: st <= S_LOAD;
               S_LOAD: begin
                  st    <= S_LO;
                  hi_q  <= cur_byte[7:4];
                  drv_q <= {1'b1, cur_byte[3:0]};
               end
               S_LO: begin
                  st    <= S_HI;
                  drv_q <= {1'b0, hi_q};
               end
               S_HI: begin
                  if (is_last) begin
                     st    <= S_IDLE;
                     drv_q <= '0;
                  end else begin
                     st  <= S_LOAD;
                     idx <= idx + 1'b1;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end else if (expired) begin
            st    <= S_IDLE;
            drv_q <= '0;
            err_q <= 1'b1;
         end
      end
   end

   assign line_out = drv_q;
   assign tmo_err  = err_q;

   // R2: while awaiting the reply, the start code stays parked with strobe low
   a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_START) |-> (line_out == {1'b0, START_CODE}));
   // R3: the strobe drops only after the peer raised its strobe
   a_r3_fall_after_peer: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_out[4]) && !tmo_err) |-> $past(peer_stat[4]));
   // R3: the low nibble stays put while the peer has not answered
   a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LO && $past(st) == S_LO) |-> $stable(line_out));
   // R9: every wire is at zero whenever the block is idle
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> (line_out == '0));
   // R10: a timeout pulse comes from a wait and leaves the wires at zero
   a_r10_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |-> (line_out == '0 && $past(st) != S_IDLE));
endmodule

// File: tb/nib_pkt_tx_test.sv
`timescale 1ns/1ps
module nib_pkt_tx_test;
   localparam int LIMIT = 40;
   localparam int AB    = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pay_valid = 1'b0;
   logic          pay_ready;
   logic [7:0]    pay_data = '0;
   logic [15:0]   pay_len = '0;
   logic [8*AB-1:0] hdr_addr = '0;
   logic [4:0]    peer_stat = '0;
   logic [4:0]    line_out;
   logic          tmo_err;

   int checks = 0;
   int failures = 0;

   logic [7:0] src_mem [0:319];
   int src_n = 0;
   int src_i = 0;
   int stall_at = -1;
   logic [7:0] exp_b [0:339];
   int exp_n = 0;

   always #10 clk = ~clk;

   nib_pkt_tx #(.LEN_W(16), .ADDR_BYTES(AB), .WAIT_LIMIT(LIMIT)) uut (
      .clk(clk), .rst_n(rst_n), .pay_valid(pay_valid), .pay_ready(pay_ready),
      .pay_data(pay_data), .pay_len(pay_len), .hdr_addr(hdr_addr),
      .peer_stat(peer_stat), .line_out(line_out), .tmo_err(tmo_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // payload source: advances after each consumed beat
   initial forever begin
      @(negedge clk);
      if (pay_valid && pay_ready) begin
         @(posedge clk);
         #1;
         src_i++;
         if (src_i >= src_n || src_i == stall_at) pay_valid = 1'b0;
         else pay_data = src_mem[src_i];
      end
   end

   task automatic build(input int n, input int seed);
      int s = 0;
      int fl = n + AB + 2;
      for (int k = 0; k < AB; k++) hdr_addr[8*k +: 8] = 8'(k * seed + 3);
      for (int i = 0; i < n; i++) src_mem[i] = 8'(i * 37 + seed * 11 + 5);
      exp_b[0] = 8'(fl);
      exp_b[1] = 8'(fl >> 8);
      for (int k = 0; k < AB; k++) begin
         exp_b[2+k] = hdr_addr[8*k +: 8];
         s += hdr_addr[8*k +: 8];
      end
      exp_b[AB+2] = 8'h08;
      exp_b[AB+3] = 8'h00;
      s += 8;
      for (int i = 0; i < n; i++) begin
         exp_b[AB+4+i] = src_mem[i];
         s += src_mem[i];
      end
      exp_b[AB+4+n] = 8'(s);
      exp_n = AB + 5 + n;
   endtask

   task automatic wait_hs(input bit v, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (line_out[4] == v) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic wait_err(output int cnt);
      cnt = 0;
      while (cnt < 120) begin
         @(negedge clk);
         cnt++;
         if (tmo_err) break;
      end
   endtask

   // present the start beat, check the start code (R2), then reply
   task automatic begin_frame(input int n);
      bit seen = 1'b0;
      @(posedge clk); #1;
      src_i = 0;
      src_n = (n == 0) ? 1 : n;
      pay_len = 16'(n);
      pay_data = src_mem[0];
      pay_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (line_out != 5'h00) begin
            seen = 1'b1;
            break;
         end
      end
      chk(seen && line_out == 5'h08, "R2 start code", line_out, 5'h08);
      if (n == 0) chk(pay_valid == 1'b0, "R8 empty beat consumed at start", pay_valid, 0);
      else        chk(pay_valid == 1'b1, "R7 first beat kept until its slot", pay_valid, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(line_out == 5'h08, "R2 held until reply", line_out, 5'h08);
      end
      @(posedge clk); #1;
      peer_stat = 5'h01;
   endtask

   task automatic xfer(input int first, input int count, input int n, input int dly);
      bit ok;
      logic [3:0] lo, hi;
      for (int b = first; b < first + count; b++) begin
         wait_hs(1'b1, ok);
         chk(ok, "R3 strobe raised for low nibble", ok, 1);
         if (!ok) return;
         lo = line_out[3:0];
         repeat ((b + dly) % 4) begin
            @(negedge clk);
            chk(line_out == {1'b1, lo}, "R3 low nibble held", line_out, {1'b1, lo});
         end
         @(posedge clk); #1;
         peer_stat[4] = 1'b1;
         wait_hs(1'b0, ok);
         chk(ok, "R3 strobe lowered for high nibble", ok, 1);
         if (!ok) return;
         hi = line_out[3:0];
         @(posedge clk); #1;
         peer_stat[4] = 1'b0;
         if (b < 2)                chk({hi, lo} == exp_b[b], "R5 length byte", {hi, lo}, exp_b[b]);
         else if (b == exp_n - 1)  chk({hi, lo} == exp_b[b], "R6 checksum byte", {hi, lo}, exp_b[b]);
         else if (b >= AB + 4)     chk({hi, lo} == exp_b[b], "R7 payload byte", {hi, lo}, exp_b[b]);
         else                      chk({hi, lo} == exp_b[b], "R4 header byte", {hi, lo}, exp_b[b]);
      end
   endtask

   task automatic run_frame(input int n, input int seed, input int dly);
      build(n, seed);
      begin_frame(n);
      xfer(0, exp_n, n, dly);
      repeat (2) @(negedge clk);
      chk(line_out == 5'h00, "R9 wires parked after checksum", line_out, 0);
      chk(pay_valid == 1'b0, "R7 all payload consumed", pay_valid, 0);
      if (n == 0) chk(exp_b[0] == 8'(AB + 2), "R8 empty frame length", exp_b[0], AB + 2);
      @(posedge clk); #1;
      peer_stat = 5'h00;
   endtask

   initial begin
      int cnt;
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int cnt;
      bit ok;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(line_out == 5'h00, "R1 reset wires", line_out, 0);
      chk(pay_ready == 1'b0, "R1 reset ready", pay_ready, 0);
      chk(tmo_err == 1'b0, "R1 reset error", tmo_err, 0);

      // sweep of payload lengths, including empty (R8)
      for (int n = 0; n <= 20; n++) run_frame(n, n + 1, n % 4);
      // length with nonzero high byte (R5)
      run_frame(260, 7, 1);

      // R10 no start reply
      build(3, 2);
      @(posedge clk); #1;
      src_i = 0; src_n = 3; pay_len = 16'd3; pay_data = src_mem[0]; pay_valid = 1'b1;
      wait_err(cnt);
      pay_valid = 1'b0;
      chk(tmo_err && cnt >= LIMIT - 2 && cnt <= LIMIT + 4, "R10 start reply timeout", cnt, LIMIT + 1);
      chk(line_out == 5'h00, "R10 wires zero on timeout", line_out, 0);
      repeat (3) @(negedge clk);
      chk(line_out == 5'h00 && tmo_err == 1'b0, "R10 stays idle after timeout", line_out, 0);

      // R10 peer never raises its strobe
      build(2, 4);
      begin_frame(2);
      wait_hs(1'b1, ok);
      wait_err(cnt);
      pay_valid = 1'b0;
      chk(tmo_err == 1'b1, "R10 strobe timeout", tmo_err, 1);
      chk(line_out == 5'h00, "R10 wires zero on strobe timeout", line_out, 0);
      @(posedge clk); #1; peer_stat = 5'h00;

      // R10 payload stream stalls mid-frame
      build(5, 9);
      stall_at = 2;
      begin_frame(5);
      xfer(0, AB + 6, 5, 0);
      wait_err(cnt);
      chk(tmo_err == 1'b1, "R10 payload stall timeout", tmo_err, 1);
      chk(line_out == 5'h00, "R10 wires zero on stall timeout", line_out, 0);
      stall_at = -1;
      @(posedge clk); #1; peer_stat = 5'h00;
      repeat (3) @(negedge clk);

      // R10 recovery frame
      run_frame(3, 13, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule